// File: doc/BRIEF.md
# Shared-Bus Configuration Sequencer

This block sits on the programmer side of a board. One SPI bus, with a single chip-select line, reaches both a serial configuration flash and the configuration port of an FPGA. The sequencer drives that bus and the FPGA's active-low reset line. After a start pulse it runs one of two paths, chosen by a mode input that is sampled at the start pulse.

In the **flash path**, the FPGA is held in reset for the whole session, so it cannot claim the bus as a controller. The flash is first woken by command, and then the payload is written to it as one framed transfer. The payload carries whatever flash opcodes the caller wants.

In the **direct path**, the flash is first put to sleep by command, so that it ignores further bus traffic. The data roles at the two pins are then swapped. The chip select is pulled low, and the FPGA reset is released while the chip select is low, so the FPGA comes up as a peripheral. The payload is then streamed into the FPGA. Finally, a run of trailing clocks with the chip select high lets the FPGA finish its startup.

Payload bytes come from a valid/ready byte source with a last-byte marker. The sequencer pauses the bus clock whenever the source stalls. A one-cycle done pulse marks the end of either path.

Top module: `cfg_seq`

## Requirements
- R1: Out of reset and while idle: `cs_n` is 1, `sclk` is 0, `creset_n` is 1, `pin_mosi_oe`, `pin_miso_oe`, `in_ready` and `done` are all 0.
- R2: A start pulse drives `creset_n` to 0 before the first chip-select frame. In the flash path (`path_direct` = 0), `creset_n` stays 0 for every byte on the bus and rises only after `cs_n` has returned high at the end.
- R3: In the flash path, the first frame is a single byte 0xAB (wake from deep power-down) on `pin_mosi`. It is followed by one frame holding the whole payload on `pin_mosi`.
- R4: In the direct path (`path_direct` = 1), the first frame is a single byte 0xB9 (deep power-down) on `pin_mosi`, sent with `creset_n` at 0.
- R5: In the direct path, every payload byte is driven on `pin_miso` with `pin_miso_oe` = 1 and `pin_mosi_oe` = 0.
- R6: Between the command frame and the payload frame, `cs_n` stays high for at least one SCLK period (2·HALF clock cycles).
- R7: In the direct path, `creset_n` rises while `cs_n` is 0. This happens after the 0xB9 frame and before the first payload bit.
- R8: The bus runs in SPI mode 0, MSB first. `sclk` is 0 whenever `cs_n` falls, and the data pin changes only while `sclk` is low.
- R9: Payload bytes appear on the bus in the order they are accepted (`in_valid` and `in_ready` both high at a clock edge). While the source stalls, no SCLK edges are produced. The byte with `in_last` = 1 closes the frame.
- R10: In the direct path, at least TRAIL_CLKS (default 49) SCLK cycles follow the payload with `cs_n` high, before done. The flash path produces no SCLK edges with `cs_n` high.
- R11: `done` is a single-cycle pulse, one per session. `in_ready` is 1 only while `cs_n` is 0 in the payload phase.
- R12: A start pulse while a session is running is ignored. A change of `path_direct` after the start pulse has no effect on the running session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session (ignored when busy) |
| path_direct | input | 1 | 0: flash path, 1: direct FPGA configuration |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| in_ready | output | 1 | Sequencer accepts a byte this cycle |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | Shared active-low chip select |
| pin_mosi | output | 1 | Data on the flash-input net |
| pin_mosi_oe | output | 1 | Drive enable for pin_mosi |
| pin_miso | output | 1 | Data on the flash-output net (FPGA input) |
| pin_miso_oe | output | 1 | Drive enable for pin_miso |
| creset_n | output | 1 | FPGA active-low reset |
| done | output | 1 | One-cycle end-of-session pulse |

## Verification
The bench decodes the bus at the pins and checks the following:
- **Opcode and pin per path.** A design that sent the wrong opcode, or drove the payload on the unswapped pin, would be caught from the decoded frames.
- **Reset timing.** A design that released reset before the sleep command, or while the chip select was high, would let the FPGA boot as a controller. The bench catches this through the frame index and the `cs_n` level recorded at the reset rising edge.
- **Source stalls.** A design that kept clocking during a stall would add or corrupt bytes, and the bench counts and compares every payload byte.
- **Separation gap and trailer.** Too short a gap between frames, or too few trailing clocks, is measured directly.
- **Start and mode during a session.** Stray start pulses and mode changes are applied mid-session to show that a sloppy design would run twice or switch paths.

// File: rtl/cfg_seq.sv
`timescale 1ns/1ps
module cfg_seq #(
  parameter int HALF       = 2,
  parameter int RST_TICKS  = 4,
  parameter int GAP_TICKS  = 2,
  parameter int WAKE_TICKS = 4,
  parameter int TRAIL_CLKS = 49
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       path_direct,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       sclk,
  output logic       cs_n,
  output logic       pin_mosi,
  output logic       pin_mosi_oe,
  output logic       pin_miso,
  output logic       pin_miso_oe,
  output logic       creset_n,
  output logic       done
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CW = $clog2(TRAIL_CLKS + RST_TICKS + GAP_TICKS + WAKE_TICKS + 2);
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [2:0] {
    S_IDLE, S_RST_LOW, S_CMD, S_GAP, S_RST_REL, S_STREAM, S_TRAIL, S_DONE
  } st_t;

  st_t           st;
  logic [DW-1:0] div;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          have, last_q, dir_q, swap, sclk_q, cs_q, rst_q;

  wire tick = (div == DW'(HALF - 1));
  wire take = in_ready && in_valid;

  assign in_ready    = (st == S_STREAM) && !have;
  assign sclk        = sclk_q;
  assign cs_n        = cs_q;
  assign creset_n    = rst_q;
  assign done        = (st == S_DONE);
  assign pin_mosi    = sh[7];
  assign pin_miso    = sh[7];
  assign pin_mosi_oe = (st != S_IDLE) && !swap;
  assign pin_miso_oe = swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; cnt <= '0; sh <= '0; bitn <= '0;
      have <= 1'b0; last_q <= 1'b0; dir_q <= 1'b0; swap <= 1'b0;
      sclk_q <= 1'b0; cs_q <= 1'b1; rst_q <= 1'b1;
    end else begin
      div <= (tick || st == S_IDLE || take) ? '0 : div + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          dir_q <= path_direct; rst_q <= 1'b0; cnt <= '0; st <= S_RST_LOW;
        end
        S_RST_LOW: if (tick) begin
          if (cnt == CW'(RST_TICKS - 1)) begin
            cnt <= '0; cs_q <= 1'b0; sh <= dir_q ? OP_SLEEP : OP_WAKE;
            have <= 1'b1; bitn <= '0; st <= S_CMD;
          end else cnt <= cnt + 1'b1;
        end
        S_CMD, S_STREAM: begin
          if (take) begin
            sh <= in_data; last_q <= in_last; have <= 1'b1; bitn <= '0;
          end else if (tick && have) begin
            if (!sclk_q) sclk_q <= 1'b1;
            else begin
              sclk_q <= 1'b0;
              if (bitn == 3'd7) begin
                have <= 1'b0;
                if (st == S_CMD) begin
                  cs_q <= 1'b1; cnt <= '0; st <= S_GAP;
                end else if (last_q) begin
                  cs_q <= 1'b1; cnt <= '0; st <= dir_q ? S_TRAIL : S_DONE;
                end
              end else begin
                sh <= {sh[6:0], 1'b0}; bitn <= bitn + 1'b1;
              end
            end
          end
        end
        S_GAP: if (tick) begin
          if (cnt == CW'(GAP_TICKS - 1)) begin
            cnt <= '0; cs_q <= 1'b0;
            if (dir_q) begin swap <= 1'b1; st <= S_RST_REL; end
            else st <= S_STREAM;
          end else cnt <= cnt + 1'b1;
        end
        S_RST_REL: if (tick) begin
          rst_q <= 1'b1;
          if (cnt == CW'(WAKE_TICKS - 1)) begin cnt <= '0; st <= S_STREAM; end
          else cnt <= cnt + 1'b1;
        end
        S_TRAIL: if (tick) begin
          if (!sclk_q) sclk_q <= 1'b1;
          else begin
            sclk_q <= 1'b0;
            if (cnt == CW'(TRAIL_CLKS - 1)) st <= S_DONE;
            else cnt <= cnt + 1'b1;
          end
        end
        default: begin
          rst_q <= 1'b1; swap <= 1'b0; st <= S_IDLE;
        end
      endcase
    end
  end

  p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> (!sclk || $stable(pin_mosi)));
  p_cs_fall_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  p_flash_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD || (st == S_STREAM && !dir_q)) |-> !creset_n);
  p_release_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(creset_n) && swap) |-> !cs_n);
  p_trail_cs_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRAIL) |-> cs_n);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_framed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cs_n);
endmodule

// File: tb/test_cfg_seq.sv
`timescale 1ns/1ps
module test_cfg_seq;
  logic clk = 0, rst_n = 0, start = 0, path_direct = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, sclk, cs_n, pin_mosi, pin_mosi_oe, pin_miso, pin_miso_oe, creset_n, done;

  always #10 clk = ~clk;

  cfg_seq i_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .path_direct(path_direct),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .sclk(sclk), .cs_n(cs_n), .pin_mosi(pin_mosi), .pin_mosi_oe(pin_mosi_oe),
    .pin_miso(pin_miso), .pin_miso_oe(pin_miso_oe), .creset_n(creset_n), .done(done));

  int total = 0, bad = 0;
  int nfr, nrx, bc, ntrail, ndone, rdy_bad, fall_bad;
  logic [7:0] acc;
  logic [7:0] rx [0:63];
  int   rxfr [0:63];
  bit   rxpin [0:63];
  bit   rxrst [0:63];
  realtime t_up, gap_min;
  bit   rel_seen, rel_cs;
  int   rel_nfr, rel_nrx;

  // mode[15], count[14:9], seed[8:1], stall[0]
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 6'd4,  8'h11, 1'b0},
    {1'b1, 6'd4,  8'h5A, 1'b0},
    {1'b1, 6'd1,  8'hFF, 1'b0},
    {1'b0, 6'd1,  8'h00, 1'b1},
    {1'b1, 6'd12, 8'hC3, 1'b1},
    {1'b0, 6'd9,  8'h80, 1'b1}
  };

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr();
    nfr = 0; nrx = 0; bc = 0; ntrail = 0; ndone = 0; rdy_bad = 0; fall_bad = 0;
    gap_min = 1.0e9; rel_seen = 0; rel_cs = 1; rel_nfr = -1; rel_nrx = -1;
  endtask

  always @(negedge cs_n) if (rst_n) begin
    if (nfr > 0 && ($realtime - t_up) < gap_min) gap_min = $realtime - t_up;
    if (sclk !== 1'b0) fall_bad++;
    nfr++; bc = 0;
  end
  always @(posedge cs_n) t_up = $realtime;

  always @(posedge sclk) if (rst_n) begin
    if (cs_n === 1'b0) begin
      acc = {acc[6:0], (pin_miso_oe ? pin_miso : pin_mosi)};
      bc++;
      if (bc == 8) begin
        if (nrx < 64) begin
          rx[nrx] = acc; rxfr[nrx] = nfr; rxpin[nrx] = pin_miso_oe; rxrst[nrx] = creset_n;
        end
        nrx++; bc = 0;
      end
    end else ntrail++;
  end

  always @(posedge creset_n) if (rst_n && !rel_seen) begin
    rel_seen = 1; rel_cs = cs_n; rel_nfr = nfr; rel_nrx = nrx;
  end

  always @(negedge clk) if (rst_n) begin
    if (done === 1'b1) ndone++;
    if (in_ready === 1'b1 && cs_n !== 1'b0) rdy_bad++;
  end

  task automatic send(int n, logic [7:0] seed, bit stall);
    for (int i = 0; i < n; i++) begin
      if (stall) repeat (5 + i) @(negedge clk);
      @(negedge clk);
      in_valid = 1; in_data = seed + 8'(i * 37); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 0; in_last = 0;
    end
  endtask

  task automatic run_vec(bit mode, int n, logic [7:0] seed, bit stall);
    int w;
    clr();
    @(negedge clk); path_direct = mode; start = 1;
    @(negedge clk); start = 0; path_direct = !mode;     // R12 mode sampled at start
    repeat (2) @(negedge clk);
    start = 1; @(negedge clk); start = 0;               // R12 start while busy
    send(n, seed, stall);
    w = 0;
    while (ndone == 0 && w < 20000) begin @(negedge clk); w++; end
    chk(ndone != 0, "R11 session finished", ndone, 1);
    repeat (40) @(negedge clk);
    chk(nfr == 2, "R12 exactly two frames", nfr, 2);
    chk(nrx == n + 1, "R9 byte count", nrx, n + 1);
    chk(rx[0] == (mode ? 8'hB9 : 8'hAB), mode ? "R4 sleep opcode" : "R3 wake opcode",
        rx[0], mode ? 8'hB9 : 8'hAB);
    chk(rxpin[0] == 0 && rxrst[0] == 0, "R2 command on mosi with reset low",
        {rxpin[0], rxrst[0]}, 0);
    for (int i = 0; i < n && i < 63; i++) begin
      logic [7:0] e;
      e = seed + 8'(i * 37);
      chk(rx[i+1] == e && rxfr[i+1] == 2, "R9 payload byte", rx[i+1], e);
      chk(rxpin[i+1] == mode, mode ? "R5 payload on miso" : "R3 payload on mosi",
          rxpin[i+1], mode);
      chk(rxrst[i+1] == mode, mode ? "R7 reset released for payload" : "R2 reset held for payload",
          rxrst[i+1], mode);
    end
    chk(gap_min >= 80.0, "R6 cs high gap ns", int'(gap_min), 80);
    chk(fall_bad == 0, "R8 sclk low at cs fall", fall_bad, 0);
    if (mode) begin
      chk(rel_cs == 0 && rel_nfr == 2 && rel_nrx == 1, "R7 release inside frame after sleep",
          {rel_cs, 8'(rel_nfr), 8'(rel_nrx)}, 16'h0201);
      chk(ntrail >= 49, "R10 trailer clocks", ntrail, 49);
    end else begin
      chk(rel_cs == 1 && rel_nrx == n + 1, "R2 release after final frame",
          {rel_cs, 8'(rel_nrx)}, {1'b1, 8'(n + 1)});
      chk(ntrail == 0, "R10 no flash trailer", ntrail, 0);
    end
    chk(ndone == 1, "R11 single done pulse", ndone, 1);
    chk(rdy_bad == 0, "R11 ready only in frame", rdy_bad, 0);
    chk(cs_n && !sclk && creset_n && !pin_mosi_oe && !pin_miso_oe, "R1 idle after session",
        {cs_n, sclk, creset_n, pin_mosi_oe, pin_miso_oe}, 5'b10100);
  endtask

  initial begin
    #3000000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && creset_n && !pin_mosi_oe && !pin_miso_oe && !in_ready && !done,
        "R1 reset state", {cs_n, sclk, creset_n, pin_mosi_oe, pin_miso_oe, in_ready, done},
        7'b1010000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 6; v++)
      run_vec(VEC[v][15], int'(VEC[v][14:9]), VEC[v][8:1], VEC[v][0]);
    // reset in the middle of a direct session
    clr();
    @(negedge clk); path_direct = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(!creset_n && !cs_n, "R2 reset low during sleep command", {creset_n, cs_n}, 0);
    rst_n = 0; #1;
    chk(cs_n && !sclk && creset_n && !pin_mosi_oe && !pin_miso_oe && !done, "R1 reset mid session",
        {cs_n, sclk, creset_n, pin_mosi_oe, pin_miso_oe, done}, 6'b101000);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    run_vec(1'b1, 3, 8'h3C, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule